// File: doc/BRIEF.md
# Dual-Channel Output Demultiplexer with Combined Range Flag

This block sits behind a two-channel sampler that delivers one offset-binary code per clock on each of two channels, I and Q. Every code is first forced to a limit value when the sampler reports that the input was past full scale, so an under-range sample reads as all zeros and an over-range sample reads as all ones. The codes then travel a fixed-length pipeline to two output buses per channel, a primary bus and a delayed bus.

Each channel has its own mode pin. In full-rate mode the primary bus carries every sample and the delayed bus freezes. In split mode consecutive samples are paired: the even sample of each pair leaves on the delayed bus and the odd one on the primary bus, and both buses change together on every second clock, so each runs at half the sample rate. Sample indices restart at zero whenever a mode pin changes, and a valid output stays low while the pipeline refills. A single registered out-of-range flag summarises both channels, or only I when the Q channel is marked powered down, and it changes together with the I primary bus.

Top module: `dual_demux_range`

## Requirements
- R1: While `rst_n` is low, all four data buses, `oor` and `valid` read zero.
- R2: A sample with its under-range input high is carried as 8'h00 (under-range wins if both are high); one with only over-range high is carried as 8'hFF; otherwise the code is carried unchanged, with no recoding of its offset-binary value.
- R3: With a channel in full-rate mode (mode pin 0) at the previous edge, its primary bus after clock edge n holds the sample captured at edge n-13.
- R4: With a channel in full-rate mode at the previous edge, its delayed bus does not change at that edge.
- R5: With a channel in split mode (mode pin 1), at each edge where the sample captured 13 edges earlier has odd index, the primary bus loads that sample and the delayed bus loads the sample captured 14 edges earlier (its even partner); at all other edges both buses hold.
- R6: The range state of one sample is (I under-range or I over-range) or, only when `q_pdn` is low at that sample, (Q under-range or Q over-range).
- R7: With I in full-rate mode, `oor` takes at every edge the range state of the sample entering the I primary bus; with I in split mode, `oor` loads the OR of the two paired samples' range states when the buses load and holds otherwise.
- R8: `valid` is low for the first 14 edges after reset release, and for 14 edges following any edge at which either mode pin differs from its value at the previous edge (before the first edge that value is 0); otherwise it is high.
- R9: The two channels' modes are independent; each channel's buses follow only its own mode pin.
- R10: The sample captured at reset release or at an edge where a mode change is seen has index 0 (even), and indices then alternate every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| i_code | input | 8 | I channel offset-binary code |
| q_code | input | 8 | Q channel offset-binary code |
| i_ovr | input | 1 | I sample above positive full scale |
| i_und | input | 1 | I sample below negative full scale |
| q_ovr | input | 1 | Q sample above positive full scale |
| q_und | input | 1 | Q sample below negative full scale |
| q_pdn | input | 1 | Q channel powered down: drop Q from the range flag |
| i_split | input | 1 | I mode: 0 full-rate, 1 split |
| q_split | input | 1 | Q mode: 0 full-rate, 1 split |
| i_pri | output | 8 | I primary bus |
| i_dly | output | 8 | I delayed bus |
| q_pri | output | 8 | Q primary bus |
| q_dly | output | 8 | Q delayed bus |
| oor | output | 1 | Combined out-of-range flag, aligned with I primary bus |
| valid | output | 1 | Output data valid (pipeline refilled) |

## Verification
The hardest situation to reach is a mode pin changing again while a previous flush is still counting, because it must restart both the refill count and the even/odd pairing while old-mode samples are still in flight. The stimulus toggles the Q mode pin on consecutive edges and issues a reset in the middle of traffic with both channels in split mode, so the first edge sees a change at once. A behavioural reference with a sample history queue is compared against every output on every clock, including cycles where `valid` is low, so the bus-hold behaviour during flushes is checked as well.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  typedef enum logic {
    BUS_FULL  = 1'b0,
    BUS_SPLIT = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/dmx_clamp.sv
// Forces a code to its limit value when the sampler reports a range excursion.
module dmx_clamp #(
  parameter int W = 8
) (
  input  logic [W-1:0] raw,
  input  logic         ovr,
  input  logic         und,
  output logic [W-1:0] code
);
  always_comb begin
    if (und)      code = '0;
    else if (ovr) code = '1;
    else          code = raw;
  end
endmodule

// File: rtl/dmx_flush.sv
// Mode register, refill counter and capture index parity.
module dmx_flush
  import dmx_pkg::*;
#(
  parameter int LAT_D = 14,
  parameter int NCH   = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] mode_in,
  output logic [NCH-1:0] mode_q,
  output logic           cap_phase,
  output logic           valid
);
  localparam int CW = $clog2(LAT_D + 1);

  logic          restart;
  logic          ph_q, ph_n;
  logic [CW-1:0] cnt_q, cnt_n;

  assign restart = (mode_in != mode_q);

  always_comb begin
    cap_phase = restart ? 1'b0 : ph_q;
    ph_n      = ~cap_phase;
    if (restart)            cnt_n = CW'(LAT_D);
    else if (cnt_q != '0)   cnt_n = cnt_q - 1'b1;
    else                    cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ph_q   <= 1'b0;
      cnt_q  <= CW'(LAT_D);
    end else begin
      mode_q <= mode_in;
      ph_q   <= ph_n;
      cnt_q  <= cnt_n;
    end
  end

  assign valid = (cnt_q == '0);

  AST_FLUSH_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !valid); // R8
  AST_INDEX_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && mode_in == $past(mode_in)) |=> (cap_phase != $past(cap_phase) || restart)); // R10
endmodule

// File: rtl/dmx_delay.sv
// Fixed-length delay line; tap holds the word captured DEPTH-1 edges earlier.
module dmx_delay #(
  parameter int DW    = 18,
  parameter int DEPTH = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] tap
);
  logic [DEPTH-1:0][DW-1:0] stg;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[DEPTH-2:0], din};
      end
    end
  endgenerate

  assign tap = stg[DEPTH-1];
endmodule

// File: rtl/dmx_outsel.sv
// Per-channel output stage: full-rate pass-through or paired split buses.
module dmx_outsel
  import dmx_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bus_mode_e    mode,
  input  logic [W-1:0] p_code,
  input  logic         p_phase,
  input  logic [W-1:0] d_code,
  output logic [W-1:0] pri,
  output logic [W-1:0] dly
);
  logic pri_en, dly_en;

  always_comb begin
    pri_en = 1'b0;
    dly_en = 1'b0;
    unique case (mode)
      BUS_FULL:  pri_en = 1'b1;
      BUS_SPLIT: begin
        pri_en = p_phase;
        dly_en = p_phase;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pri <= '0;
      dly <= '0;
    end else begin
      if (pri_en) pri <= p_code;
      if (dly_en) dly <= d_code;
    end
  end

  AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BUS_FULL) |=> (pri == $past(p_code))); // R3
  AST_FULL_DLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BUS_FULL) |=> $stable(dly)); // R4
  AST_SPLIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BUS_SPLIT && !p_phase) |=> ($stable(pri) && $stable(dly))); // R5
  AST_SPLIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == BUS_SPLIT && p_phase) |=> (pri == $past(p_code) && dly == $past(d_code))); // R5
endmodule

// File: rtl/dual_demux_range.sv
module dual_demux_range
  import dmx_pkg::*;
#(
  parameter int W     = 8,
  parameter int LAT_P = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] i_code,
  input  logic [W-1:0] q_code,
  input  logic         i_ovr,
  input  logic         i_und,
  input  logic         q_ovr,
  input  logic         q_und,
  input  logic         q_pdn,
  input  logic         i_split,
  input  logic         q_split,
  output logic [W-1:0] i_pri,
  output logic [W-1:0] i_dly,
  output logic [W-1:0] q_pri,
  output logic [W-1:0] q_dly,
  output logic         oor,
  output logic         valid
);
  localparam int NCH   = 2;
  localparam int LAT_D = LAT_P + 1;
  localparam int FL    = NCH * W;     // range flag bit
  localparam int PH    = FL + 1;      // index parity bit
  localparam int DW    = PH + 1;

  logic [NCH-1:0][W-1:0] raw_c, clamp_c, pri_c, dly_c;
  logic [NCH-1:0]        ovr_c, und_c, mode_in, mode_q;
  logic                  cap_phase, cap_flag;
  logic [DW-1:0]         cap_word, tap_p;
  logic [FL:0]           d_word;
  logic                  oor_n;

  assign raw_c   = {q_code, i_code};
  assign ovr_c   = {q_ovr, i_ovr};
  assign und_c   = {q_und, i_und};
  assign mode_in = {q_split, i_split};

  dmx_flush #(.LAT_D(LAT_D), .NCH(NCH)) u_flush (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_in   (mode_in),
    .mode_q    (mode_q),
    .cap_phase (cap_phase),
    .valid     (valid)
  );

  assign cap_flag = (i_ovr | i_und) | ((q_ovr | q_und) & ~q_pdn);
  assign cap_word = {cap_phase, cap_flag, clamp_c};

  dmx_delay #(.DW(DW), .DEPTH(LAT_P)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cap_word),
    .tap   (tap_p)
  );

  // one extra stage feeds the delayed buses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) d_word <= '0;
    else        d_word <= tap_p[FL:0];
  end

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dmx_clamp #(.W(W)) u_clamp (
      .raw  (raw_c[ch]),
      .ovr  (ovr_c[ch]),
      .und  (und_c[ch]),
      .code (clamp_c[ch])
    );
    dmx_outsel #(.W(W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (bus_mode_e'(mode_q[ch])),
      .p_code  (tap_p[ch*W +: W]),
      .p_phase (tap_p[PH]),
      .d_code  (d_word[ch*W +: W]),
      .pri     (pri_c[ch]),
      .dly     (dly_c[ch])
    );
  end

  assign i_pri = pri_c[0];
  assign i_dly = dly_c[0];
  assign q_pri = pri_c[1];
  assign q_dly = dly_c[1];

  // range flag follows the I primary bus
  always_comb begin
    oor_n = oor;
    if (mode_q[0] == BUS_FULL)  oor_n = tap_p[FL];
    else if (tap_p[PH])         oor_n = tap_p[FL] | d_word[FL];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oor <= 1'b0;
    else        oor <= oor_n;
  end

  AST_OOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] == BUS_SPLIT && !tap_p[PH]) |=> $stable(oor)); // R7
  AST_OOR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[0] == BUS_FULL) |=> (oor == $past(tap_p[FL]))); // R7
endmodule

// File: tb/sim_dual_demux_range.sv
module sim_dual_demux_range;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] i_code, q_code;
  logic       i_ovr, i_und, q_ovr, q_und, q_pdn, i_split, q_split;
  logic [7:0] i_pri, i_dly, q_pri, q_dly;
  logic       oor, valid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  dual_demux_range u0 (.*);

  typedef struct packed {
    logic [7:0] ci, cq;
    logic       fl, ph, clp;
  } rec_t;

  rec_t       hq[$];
  logic       mpi, mpq, ph;
  int         cnt, since_chg;
  logic [7:0] e_ipri, e_idly, e_qpri, e_qdly;
  logic       e_oor, e_valid;

  function automatic logic [7:0] lim(input logic [7:0] c, input logic o, input logic u);
    if (u) return 8'h00;
    if (o) return 8'hFF;
    return c;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hq.delete();
      for (int k = 0; k < 15; k++) hq.push_front('0);
      mpi = 0; mpq = 0; ph = 0; cnt = 14; since_chg = 0;
      e_ipri = 0; e_idly = 0; e_qpri = 0; e_qdly = 0; e_oor = 0; e_valid = 0;
    end else begin
      rec_t r;
      logic chg, ps;
      chg = (i_split !== mpi) || (q_split !== mpq);
      ps  = chg ? 1'b0 : ph;
      ph  = ~ps;
      if (chg) begin cnt = 14; since_chg = 0; end
      else begin if (cnt > 0) cnt--; since_chg++; end
      r.ci  = lim(i_code, i_ovr, i_und);
      r.cq  = lim(q_code, q_ovr, q_und);
      r.fl  = i_ovr | i_und | ((q_ovr | q_und) & ~q_pdn);
      r.ph  = ps;
      r.clp = i_ovr | i_und;
      hq.push_front(r);
      void'(hq.pop_back());
      if (!mpi) e_ipri = hq[13].ci;
      else if (hq[13].ph) begin e_ipri = hq[13].ci; e_idly = hq[14].ci; end
      if (!mpq) e_qpri = hq[13].cq;
      else if (hq[13].ph) begin e_qpri = hq[13].cq; e_qdly = hq[14].cq; end
      if (!mpi) e_oor = hq[13].fl;
      else if (hq[13].ph) e_oor = hq[13].fl | hq[14].fl;
      e_valid = (cnt == 0);
      mpi = i_split; mpq = q_split;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      chk("R8 valid", {7'd0, valid}, {7'd0, e_valid});
      if (!mpi) chk(hq[13].clp ? "R2 i_pri clamp" : "R3 i_pri", i_pri, e_ipri);
      else      chk("R5 i_pri", i_pri, e_ipri);
      if (!mpi) chk("R4 i_dly", i_dly, e_idly);
      else      chk((since_chg < 20) ? "R10 i_dly" : "R5 i_dly", i_dly, e_idly);
      chk((mpi != mpq) ? "R9 q_pri" : "R3/R5 q_pri", q_pri, e_qpri);
      chk((mpi != mpq) ? "R9 q_dly" : "R4/R5 q_dly", q_dly, e_qdly);
      chk(mpi ? "R7 oor" : "R6 oor", {7'd0, oor}, {7'd0, e_oor});
    end
  end

  task automatic drive(input int n, input int pdn_pct);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      i_code = 8'($urandom);
      q_code = 8'($urandom);
      i_ovr  = ($urandom % 6) == 0;
      i_und  = ($urandom % 6) == 0;
      q_ovr  = ($urandom % 6) == 0;
      q_und  = ($urandom % 6) == 0;
      q_pdn  = ($urandom % 100) < pdn_pct;
    end
  endtask

  task automatic reset_check;
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    chk("R1 i_pri", i_pri, 8'h00);
    chk("R1 i_dly", i_dly, 8'h00);
    chk("R1 q_pri", q_pri, 8'h00);
    chk("R1 q_dly", q_dly, 8'h00);
    chk("R1 oor/valid", {6'd0, oor, valid}, 8'h00);
  endtask

  initial begin
    rst_n = 0; i_code = 0; q_code = 0; i_ovr = 0; i_und = 0;
    q_ovr = 0; q_und = 0; q_pdn = 0; i_split = 0; q_split = 0;
    reset_check();
    @(negedge clk); rst_n = 1;
    drive(40, 0);
    drive(30, 60);
    i_split = 1;                 drive(60, 30);
    q_split = 1;                 drive(60, 50);
    // back-to-back mode changes restart the flush while it is counting
    q_split = 0; drive(1, 20);
    q_split = 1; drive(1, 20);
    q_split = 0; drive(3, 20);
    q_split = 1; drive(40, 20);
    i_split = 0; q_split = 1;    drive(50, 40);
    i_split = 1; q_split = 0;    drive(50, 40);
    // reset in traffic, released with both channels in split mode
    i_split = 1; q_split = 1;
    reset_check();
    @(negedge clk); rst_n = 1;
    drive(60, 50);
    i_split = 0; q_split = 0;    drive(40, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule